// File: doc/BRIEF.md
# Multi-Port Tree Pseudo-LRU Record Array

This block holds one tree pseudo-LRU record for each set of a set-associative cache. Several hit ports each name a set and a way. The record of that set is then updated so the way counts as most recently used. A victim port names a set and gets back the way that was least recently used. In the same operation that way is marked as used, so the next victim request for the set picks a different way. An initialise port writes a record value directly. It also cancels any update that is still in flight.

For N ways a record holds N-1 bits that form a binary decision tree. Node k (1-based) is stored at record bit k-1. Its left child is node 2k and its right child is node 2k+1. A search for the victim starts at the root. It goes left on a 0 and right on a 1. Marking a way used sets every node on that way's path so that it points away from the way. When several ports reach the same set in one cycle, their marks are folded into a single record write, so no update is lost. A request that follows an earlier request to the same set in the next cycle sees the record that the earlier request produced.

Top module: `plruMultiPortArray`

## Requirements
- R1: In the default 4-way setup, record bit 0 is the root, bit 1 chooses between ways 0 and 1, and bit 2 chooses between ways 2 and 3. The victim is way 0 when bits 0 and 1 are both 0, way 1 when bit 0 is 0 and bit 1 is 1, way 2 when bit 0 is 1 and bit 2 is 0, and way 3 when bit 0 is 1 and bit 2 is 1.
- R2: Marking way 0 used sets bit 0=1 and bit 1=1. Way 1 sets bit 0=1 and bit 1=0. Way 2 sets bit 0=0 and bit 2=1. Way 3 sets bit 0=0 and bit 2=0. All other bits keep their value.
- R3: A victim request also marks the returned way as used, so that way is not returned again by the next victim request for the same set.
- R4: Hit ports that name the same set in one cycle are applied in port order, lowest index first. A victim request for that set in the same cycle picks its way from the record after those hits, and its own mark is applied last.
- R5: Requests that name different sets in the same cycle update their own records and do not disturb each other.
- R6: A request in the cycle right after another request to the same set works on the record that the earlier request produced.
- R7: A victim request sampled on a rising edge produces `vicRespValid`=1 with the way on `vicRespWay` for the following cycle. Hit-only cycles and idle cycles give `vicRespValid`=0.
- R8: An initialise write stores `initRec` at `initSet`, using the bit layout of R1. A request to that set in the next cycle sees the new value.
- R9: An initialise write discards the record updates of all requests sampled on the previous edge. Their victim responses are still delivered.
- R10: Requests sampled together with an initialise write are dropped. They give no victim response and change no record.
- R11: After reset every record is 0 and `vicRespValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| incValid | input | INC_PORTS | One hit-mark request per port |
| incSet | input | INC_PORTS*IDX_W | Set index of each hit port, port p at bits p*IDX_W upward |
| incWay | input | INC_PORTS*WAY_W | Way of each hit port, port p at bits p*WAY_W upward |
| vicReq | input | 1 | Victim request |
| vicSet | input | IDX_W | Set index of the victim request |
| initValid | input | 1 | Initialise write strobe |
| initSet | input | IDX_W | Set written by the initialise port |
| initRec | input | WAY_CNT-1 | Record value written by the initialise port |
| vicRespValid | output | 1 | Victim response valid |
| vicRespWay | output | WAY_W | Least recently used way of the requested set |

## Verification
A victim response is due in the cycle that follows the rising edge that sampled the request. The bench applies each stimulus at a falling edge and reads the response at the next falling edge, which is the midpoint of that response cycle. The effect of a hit or an initialise write cannot be seen directly. It shows up only through the way returned by a later victim request. Those probes are issued back to back, so they exercise the forwarding of the newest record. Runs where an initialise write lands one cycle after a request, or in the same cycle as one, confirm that the record is unchanged afterwards.

// File: rtl/plru_pkg.sv
package plru_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic capture;   // accept requests at this edge
    logic commit;    // write merged records of the stage-1 requests
    logic clearFwd;  // invalidate forwarded records
  } plruStrobe_t;

endpackage

// File: rtl/plruPick.sv
// Walks the tree from the root to a leaf: a 0 goes left, a 1 goes right.
module plruPick #(
  parameter int WAY_CNT = 4,
  localparam int REC_W = WAY_CNT - 1,
  localparam int WAY_W = $clog2(WAY_CNT),
  localparam int LVLS  = $clog2(WAY_CNT)
) (
  input  logic [REC_W-1:0] rec,
  output logic [WAY_W-1:0] way
);

  always_comb begin
    int node;
    node = 1;
    for (int l = 0; l < LVLS; l++) begin
      node = node * 2 + int'(rec[node-1]);
    end
    way = WAY_W'(node - WAY_CNT);
  end

endmodule

// File: rtl/plruFold.sv
// Applies a list of mark-used operations to one record, in list order.
module plruFold #(
  parameter int WAY_CNT = 4,
  parameter int MARKS   = 2,
  localparam int REC_W = WAY_CNT - 1,
  localparam int WAY_W = $clog2(WAY_CNT),
  localparam int LVLS  = $clog2(WAY_CNT)
) (
  input  logic [REC_W-1:0]       base,
  input  logic [MARKS-1:0]       markEn,
  input  logic [MARKS*WAY_W-1:0] markWay,
  output logic [REC_W-1:0]       rec
);

  function automatic logic [REC_W-1:0] markUsed(input logic [REC_W-1:0] r,
                                                input logic [WAY_W-1:0] w);
    logic [REC_W-1:0] t;
    int node;
    t = r;
    node = int'(w) + WAY_CNT;
    for (int l = 0; l < LVLS; l++) begin
      int parent;
      parent = node / 2;
      // point each ancestor away from the used leaf
      t[parent-1] = (node % 2 == 0);
      node = parent;
    end
    return t;
  endfunction

  always_comb begin
    rec = base;
    for (int m = 0; m < MARKS; m++) begin
      if (markEn[m]) rec = markUsed(rec, markWay[m*WAY_W +: WAY_W]);
    end
  end

endmodule

// File: rtl/plruCtrl.sv
module plruCtrl
  import plru_pkg::*;
(
  input  logic        initValid,
  output plruStrobe_t ctl
);

  // An initialise write wins over everything in flight
  always_comb begin
    ctl.capture  = !initValid;
    ctl.commit   = !initValid;
    ctl.clearFwd = initValid;
  end

endmodule

// File: rtl/plruDatapath.sv
module plruDatapath
  import plru_pkg::*;
#(
  parameter int WAY_CNT   = 4,
  parameter int INC_PORTS = 2,
  parameter int SET_CNT   = 1024,
  localparam int NQ    = INC_PORTS + 1,
  localparam int VQ    = INC_PORTS,
  localparam int IDX_W = $clog2(SET_CNT),
  localparam int WAY_W = $clog2(WAY_CNT),
  localparam int REC_W = WAY_CNT - 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  plruStrobe_t                ctl,
  input  logic [INC_PORTS-1:0]       incValid,
  input  logic [INC_PORTS*IDX_W-1:0] incSet,
  input  logic [INC_PORTS*WAY_W-1:0] incWay,
  input  logic                       vicReq,
  input  logic [IDX_W-1:0]           vicSet,
  input  logic                       initValid,
  input  logic [IDX_W-1:0]           initSet,
  input  logic [REC_W-1:0]           initRec,
  output logic                       vicRespValid,
  output logic [WAY_W-1:0]           vicRespWay
);

  logic [REC_W-1:0] mem [SET_CNT];

  logic [NQ-1:0]    inValid;
  logic [IDX_W-1:0] inSet [NQ];

  logic [NQ-1:0]    s1Valid;
  logic [IDX_W-1:0] s1Set [NQ];
  logic [REC_W-1:0] s1Rd  [NQ];
  logic [WAY_W-1:0] s1Way [INC_PORTS];
  logic [INC_PORTS*WAY_W-1:0] s1WayFlat;

  logic [NQ-1:0]    fwdValid;
  logic [IDX_W-1:0] fwdSet [NQ];
  logic [REC_W-1:0] fwdRec [NQ];

  logic [REC_W-1:0]     base     [NQ];
  logic [INC_PORTS-1:0] incHit   [NQ];
  logic [NQ-1:0]        vicHit;
  logic [REC_W-1:0]     recInc   [NQ];
  logic [REC_W-1:0]     recFinal [NQ];
  logic [WAY_W-1:0]     vicWay;

  // Request slots: hit ports first, victim port last
  always_comb begin
    for (int p = 0; p < INC_PORTS; p++) begin
      inValid[p] = incValid[p];
      inSet[p]   = incSet[p*IDX_W +: IDX_W];
    end
    inValid[VQ] = vicReq;
    inSet[VQ]   = vicSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SET_CNT; s++) mem[s] <= '0;
      s1Valid  <= '0;
      fwdValid <= '0;
      for (int q = 0; q < NQ; q++) begin
        s1Set[q]  <= '0;
        s1Rd[q]   <= '0;
        fwdSet[q] <= '0;
        fwdRec[q] <= '0;
      end
      for (int p = 0; p < INC_PORTS; p++) s1Way[p] <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        s1Valid[q] <= ctl.capture && inValid[q];
        s1Set[q]   <= inSet[q];
        s1Rd[q]    <= mem[inSet[q]];
      end
      for (int p = 0; p < INC_PORTS; p++) s1Way[p] <= incWay[p*WAY_W +: WAY_W];
      // slots sharing a set carry the same merged record
      for (int q = 0; q < NQ; q++) begin
        if (ctl.commit && s1Valid[q]) mem[s1Set[q]] <= recFinal[q];
      end
      if (initValid) mem[initSet] <= initRec;
      for (int q = 0; q < NQ; q++) begin
        fwdValid[q] <= !ctl.clearFwd && ctl.commit && s1Valid[q];
        fwdSet[q]   <= s1Set[q];
        fwdRec[q]   <= recFinal[q];
      end
    end
  end

  // Newest record: writes of the previous edge beat the array read
  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      base[q] = s1Rd[q];
      for (int j = 0; j < NQ; j++) begin
        if (fwdValid[j] && fwdSet[j] == s1Set[q]) base[q] = fwdRec[j];
      end
      for (int p = 0; p < INC_PORTS; p++) begin
        incHit[q][p] = s1Valid[p] && s1Set[p] == s1Set[q];
      end
      vicHit[q] = s1Valid[VQ] && s1Set[VQ] == s1Set[q];
    end
    for (int p = 0; p < INC_PORTS; p++) s1WayFlat[p*WAY_W +: WAY_W] = s1Way[p];
  end

  for (genvar q = 0; q < NQ; q++) begin : gSlot
    plruFold #(.WAY_CNT(WAY_CNT), .MARKS(INC_PORTS)) uIncFold (
      .base(base[q]), .markEn(incHit[q]), .markWay(s1WayFlat), .rec(recInc[q]));
    plruFold #(.WAY_CNT(WAY_CNT), .MARKS(1)) uVicFold (
      .base(recInc[q]), .markEn(vicHit[q]), .markWay(vicWay), .rec(recFinal[q]));
  end

  plruPick #(.WAY_CNT(WAY_CNT)) uPick (.rec(recInc[VQ]), .way(vicWay));

  assign vicRespValid = s1Valid[VQ];
  assign vicRespWay   = vicWay;

  // R4: every slot of one set computes the same merged record
  for (genvar a = 0; a < NQ; a++) begin : gAgreeA
    for (genvar b = a + 1; b < NQ; b++) begin : gAgreeB
      a_r4_merge_agree: assert property (@(posedge clk) disable iff (!rstN)
        (s1Valid[a] && s1Valid[b] && s1Set[a] == s1Set[b]) |-> recFinal[a] == recFinal[b]);
    end
  end

  // R9: no record write is forwarded out of an initialise cycle
  a_r9_init_drops_commit: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> fwdValid == '0);

  // R10: requests beside an initialise write never enter stage 1
  a_r10_init_drops_capture: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> s1Valid == '0);

endmodule

// File: rtl/plruMultiPortArray.sv
module plruMultiPortArray
  import plru_pkg::*;
#(
  parameter int WAY_CNT   = 4,
  parameter int INC_PORTS = 2,
  parameter int LINE_CNT  = 4096,
  localparam int SET_CNT = LINE_CNT / WAY_CNT,
  localparam int IDX_W   = $clog2(SET_CNT),
  localparam int WAY_W   = $clog2(WAY_CNT),
  localparam int REC_W   = WAY_CNT - 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [INC_PORTS-1:0]       incValid,
  input  logic [INC_PORTS*IDX_W-1:0] incSet,
  input  logic [INC_PORTS*WAY_W-1:0] incWay,
  input  logic                       vicReq,
  input  logic [IDX_W-1:0]           vicSet,
  input  logic                       initValid,
  input  logic [IDX_W-1:0]           initSet,
  input  logic [REC_W-1:0]           initRec,
  output logic                       vicRespValid,
  output logic [WAY_W-1:0]           vicRespWay
);

  plruStrobe_t ctl;

  plruCtrl uCtrl (.initValid(initValid), .ctl(ctl));

  plruDatapath #(.WAY_CNT(WAY_CNT), .INC_PORTS(INC_PORTS), .SET_CNT(SET_CNT)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .incValid(incValid), .incSet(incSet), .incWay(incWay),
    .vicReq(vicReq), .vicSet(vicSet),
    .initValid(initValid), .initSet(initSet), .initRec(initRec),
    .vicRespValid(vicRespValid), .vicRespWay(vicRespWay));

  // R7: a response only follows a victim request that was not dropped
  a_r7_resp_after_req: assert property (@(posedge clk) disable iff (!rstN)
    vicRespValid |-> ($past(vicReq) && !$past(initValid)));

endmodule

// File: tb/plruMultiPortArray_test.sv
module plruMultiPortArray_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       i0v;
    logic [9:0] i0s;
    logic [1:0] i0w;
    logic       i1v;
    logic [9:0] i1s;
    logic [1:0] i1w;
    logic       vv;
    logic [9:0] vs;
    logic       ev;
    logic [1:0] ew;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t mkVec(input logic i0v, input int i0s, input int i0w,
                                 input logic i1v, input int i1s, input int i1w,
                                 input logic vv, input int vs,
                                 input logic ev, input int ew, input int req);
    vec_t v;
    v.i0v = i0v; v.i0s = 10'(i0s); v.i0w = 2'(i0w);
    v.i1v = i1v; v.i1s = 10'(i1s); v.i1w = 2'(i1w);
    v.vv = vv; v.vs = 10'(vs);
    v.ev = ev; v.ew = 2'(ew); v.req = 4'(req);
    return v;
  endfunction

  // i0v i0s i0w  i1v i1s i1w  vv vs  ev ew  req
  localparam vec_t TBL [13] = '{
    mkVec(0, 0, 0, 0, 0, 0, 1, 5, 1, 0, 1),   // R1 fresh set -> way 0
    mkVec(0, 0, 0, 0, 0, 0, 1, 5, 1, 2, 6),   // R6 newest record -> way 2
    mkVec(0, 0, 0, 0, 0, 0, 1, 5, 1, 1, 3),   // R3 victim marked -> way 1
    mkVec(0, 0, 0, 0, 0, 0, 1, 5, 1, 3, 2),   // R2 rule -> way 3
    mkVec(1, 7, 0, 1, 7, 2, 1, 7, 1, 1, 4),   // R4 hits 0,2 then victim -> way 1
    mkVec(0, 0, 0, 0, 0, 0, 1, 7, 1, 3, 4),   // R4 victim mark applied last
    mkVec(1, 9, 3, 1, 10, 1, 1, 9, 1, 0, 5),  // R5 two sets in one cycle
    mkVec(0, 0, 0, 0, 0, 0, 1, 10, 1, 2, 5),  // R5 other set kept its hit
    mkVec(1, 9, 1, 0, 0, 0, 0, 0, 0, 0, 7),   // R7 hit only: no response
    mkVec(0, 0, 0, 0, 0, 0, 1, 9, 1, 2, 2),   // R2 way 1 mark -> way 2
    mkVec(1, 12, 0, 1, 12, 1, 1, 12, 1, 2, 4),// R4 port order 0 then 1
    mkVec(0, 0, 0, 1, 12, 0, 1, 12, 1, 3, 4), // R4 hit on port 1 with victim
    mkVec(0, 0, 0, 0, 0, 0, 1, 12, 1, 1, 6)   // R6 back to back -> way 1
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] incValid = '0;
  logic [19:0] incSet = '0;
  logic [3:0] incWay = '0;
  logic       vicReq = 1'b0;
  logic [9:0] vicSet = '0;
  logic       initValid = 1'b0;
  logic [9:0] initSet = '0;
  logic [2:0] initRec = '0;
  logic       vicRespValid;
  logic [1:0] vicRespWay;

  int nChecks = 0;
  int nFails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plruMultiPortArray uut (
    .clk(clk), .rstN(rstN),
    .incValid(incValid), .incSet(incSet), .incWay(incWay),
    .vicReq(vicReq), .vicSet(vicSet),
    .initValid(initValid), .initSet(initSet), .initRec(initRec),
    .vicRespValid(vicRespValid), .vicRespWay(vicRespWay));

  // Drive at a falling edge, read the response at the next falling edge
  task automatic step(input vec_t v, input logic iv, input int is, input logic [2:0] ir);
    incValid = {v.i1v, v.i0v};
    incSet   = {v.i1s, v.i0s};
    incWay   = {v.i1w, v.i0w};
    vicReq   = v.vv;
    vicSet   = v.vs;
    initValid = iv;
    initSet   = 10'(is);
    initRec   = ir;
    @(negedge clk);
    nChecks++;
    if (vicRespValid !== v.ev || (v.ev && vicRespWay !== v.ew)) begin
      nFails++;
      $display("FAIL R%0d: valid/way actual=%0b/%0d expected=%0b/%0d",
               v.req, vicRespValid, vicRespWay, v.ev, v.ew);
    end
    incValid = '0; vicReq = 1'b0; initValid = 1'b0;
  endtask

  task automatic vic(input int s, input int expWay, input int req);
    step(mkVec(0, 0, 0, 0, 0, 0, 1, s, 1, expWay, req), 1'b0, 0, 3'b000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: quiet output after reset
    nChecks++;
    if (vicRespValid !== 1'b0) begin
      nFails++;
      $display("FAIL R11: valid actual=%0b expected=0", vicRespValid);
    end
    vic(1023, 0, 11);                       // R11 top set starts at zero

    for (int i = 0; i < 13; i++) step(TBL[i], 1'b0, 0, 3'b000);

    // R8: initialise write, then read it back (bits 0 and 2 set -> way 3)
    step(mkVec(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8), 1'b1, 20, 3'b101);
    vic(20, 3, 8);

    // R9: update of the preceding request is discarded by an initialise write
    vic(30, 0, 9);
    step(mkVec(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 9), 1'b1, 31, 3'b000);
    vic(30, 0, 9);

    // R10: requests beside an initialise write are dropped
    step(mkVec(1, 42, 0, 0, 0, 0, 1, 41, 0, 0, 10), 1'b1, 40, 3'b000);
    vic(41, 0, 10);
    vic(42, 0, 10);

    // R8 on set 0 (bit 1 set -> way 1), then R3 and R6
    step(mkVec(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8), 1'b1, 0, 3'b010);
    vic(0, 1, 8);
    vic(0, 2, 3);

    // R5: three different sets in one cycle
    step(mkVec(1, 60, 0, 1, 61, 2, 1, 62, 1, 0, 5), 1'b0, 0, 3'b000);
    vic(60, 2, 5);
    vic(61, 0, 5);

    // R7: idle cycle, then a record written several cycles ago
    step(mkVec(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7), 1'b0, 0, 3'b000);
    vic(1023, 2, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule